// File: doc/BRIEF.md
# UART Receive FIFO with Trigger and Idle Time-out Flags

This block sits between a UART receive engine and the CPU side of a serial port. Each byte the engine delivers arrives together with three error bits and is held in a 16-entry first-in first-out buffer. The CPU side takes bytes out with a one-cycle read request. The byte and its error bits appear on the read outputs in the cycle after the request.

The block reports its fill count along with empty, full and overflow conditions. It raises a data-available flag once the count reaches one of four fixed trigger levels. It also raises an idle time-out flag when bytes have waited unread for a programmable number of baud ticks. A software reset request drains the buffer and keeps it held clear for a fixed number of cycles. Serial sampling, register decode and interrupt routing belong to neighbouring blocks.

Top module: `uart_rx_buffer`

## Requirements
- R1: Bytes come out in arrival order with their error bits (in_err[0] parity, [1] framing, [2] break). Read data is registered, so rd_data/rd_err show the entry in the cycle after the rd_req that removed it. The buffer holds 16 entries.
- R2: `level` counts stored entries (0..16). It rises by one for each accepted byte and falls by one for each read of a non-empty buffer. `empty` is high exactly when level is 0 and `full` is high exactly when level is 16.
- R3: When a byte arrives while the buffer is full and no read happens in the same cycle, the byte is dropped and `ovf_flag` is set. The flag holds until a cycle in which `ovf_clr` is high and no new overflow occurs; a new overflow wins over the clear.
- R4: `trig_sel` selects the data-available level: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. `avail_flag` is high whenever level is at or above the selected value.
- R5: With a non-zero `tmo_cmp`, `tmo_flag` rises on the (tmo_cmp+1)-th `baud_tick` counted since the last byte was accepted or read, provided the buffer is not empty. A `tmo_cmp` of zero keeps the flag low.
- R6: A read of a non-empty buffer clears `tmo_flag` and restarts the tick count. An accepted byte also restarts the tick count.
- R7: A read while the buffer is empty returns zero on rd_data and rd_err and leaves level at 0.
- R8: A byte and a read in the same cycle leave level unchanged. This also holds when the buffer is full, and in that case no overflow is raised.
- R9: A cycle with `sw_rst_req` high empties the buffer from the next cycle on. `sw_rst_busy` then stays high for 3 cycles after the last request cycle. Bytes offered while the request or busy is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | 8 | Received byte |
| in_err | input | 3 | Error bits: [0] parity, [1] framing, [2] break |
| rd_req | input | 1 | CPU read request, one entry per cycle |
| rd_data | output | 8 | Byte removed by the previous read |
| rd_err | output | 3 | Error bits of that byte |
| trig_sel | input | 2 | Data-available level select |
| tmo_cmp | input | 9 | Idle time-out compare value, 0 disables |
| baud_tick | input | 1 | One-cycle pulse per baud period |
| sw_rst_req | input | 1 | Software receive-path reset request |
| sw_rst_busy | output | 1 | Software reset in progress |
| ovf_clr | input | 1 | Clears the overflow flag |
| level | output | 5 | Number of stored entries |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer full |
| ovf_flag | output | 1 | Sticky overflow flag |
| avail_flag | output | 1 | Level at or above the trigger |
| tmo_flag | output | 1 | Idle time-out flag |

## Verification
The properties assume that `rst` is held for at least two cycles before release, so that every `$past` sample sees a defined count. They also assume that `baud_tick` is a single-cycle pulse and that `tmo_cmp` and `trig_sel` change only while no time-out is pending. The stimulus drives every input at the falling edge and keeps each one for exactly one full cycle. It changes the compare and trigger settings only between test phases, while the buffer is empty or after the flag has been examined. The bench also issues reads only outside the software reset window, so that each read has one expected entry.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ERR_W  = 3;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rxb_entry_t;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_FOUR     = 2'd1,
        TRIG_EIGHT    = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } rxb_trig_e;

    function automatic int unsigned trig_threshold(input rxb_trig_e sel);
        case (sel)
            TRIG_ONE:      return 1;
            TRIG_FOUR:     return 4;
            TRIG_EIGHT:    return 8;
            default:       return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  rxb_entry_t push_entry,
    input  logic       pop,
    output rxb_entry_t pop_entry,
    output logic [CW-1:0] count,
    output logic       pushed,
    output logic       popped,
    output logic       drop
);

    rxb_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          is_full, is_empty;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign popped   = pop && !clr && !is_empty;
    assign pushed   = push && !clr && (!is_full || popped);
    assign drop     = push && !clr && is_full && !popped;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (pushed) begin
            mem[wptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (pushed) wptr <= ptr_next(wptr);
            if (popped) rptr <= ptr_next(rptr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else begin
            case ({pushed, popped})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pop_entry <= '0;
        end else if (pop) begin
            pop_entry <= popped ? mem[rptr] : '0;
        end
    end

endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
    parameter int unsigned TMO_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             restart,
    input  logic             popped,
    input  logic             nonempty,
    input  logic             tick,
    input  logic [TMO_W-1:0] cmp,
    output logic             flag
);

    logic [TMO_W-1:0] cnt;
    logic             armed;
    logic             hit;

    assign armed = nonempty && (cmp != '0) && !flag;
    assign hit   = armed && tick && (cnt == cmp) && !restart && !popped;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (restart || popped || !armed) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == cmp) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag <= 1'b0;
        end else if (popped) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/rxb_soft_reset.sv
module rxb_soft_reset #(
    parameter int unsigned HOLD = 3,
    localparam int unsigned HW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy,
    output logic clr
);

    logic [HW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (req) begin
            remain <= HW'(HOLD);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
    assign clr  = req || busy;

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxb_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned TMO_W     = 9,
    parameter int unsigned RST_HOLD  = 3,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ERR_W-1:0]  in_err,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    input  logic [1:0]        trig_sel,
    input  logic [TMO_W-1:0]  tmo_cmp,
    input  logic              baud_tick,
    input  logic              sw_rst_req,
    output logic              sw_rst_busy,
    input  logic              ovf_clr,
    output logic [CW-1:0]     level,
    output logic              empty,
    output logic              full,
    output logic              ovf_flag,
    output logic              avail_flag,
    output logic              tmo_flag
);

    logic       clr;
    logic       pushed, popped, drop;
    rxb_entry_t in_entry, out_entry;

    rxb_soft_reset #(.HOLD(RST_HOLD)) u_srst (
        .clk  (clk),
        .rst  (rst),
        .req  (sw_rst_req),
        .busy (sw_rst_busy),
        .clr  (clr)
    );

    assign in_entry.data = in_data;
    assign in_entry.err  = in_err;

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .push       (in_valid),
        .push_entry (in_entry),
        .pop        (rd_req),
        .pop_entry  (out_entry),
        .count      (level),
        .pushed     (pushed),
        .popped     (popped),
        .drop       (drop)
    );

    assign rd_data = out_entry.data;
    assign rd_err  = out_entry.err;
    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));

    rxb_idle_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .restart  (pushed),
        .popped   (popped),
        .nonempty (!empty),
        .tick     (baud_tick),
        .cmp      (tmo_cmp),
        .flag     (tmo_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else if (drop) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        avail_flag = (32'(level) >= trig_threshold(rxb_trig_e'(trig_sel)));
    end

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TMO_W = 9,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             rd_req,
    input logic             ovf_clr,
    input logic             sw_rst_req,
    input logic             sw_rst_busy,
    input logic [TMO_W-1:0] tmo_cmp,
    input logic [CW-1:0]    level,
    input logic             empty,
    input logic             full,
    input logic             ovf_flag,
    input logic             tmo_flag
);

    logic quiet;
    assign quiet = !sw_rst_req && !sw_rst_busy;

    p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
        quiet |=> (level == $past(level)) || (level == $past(level) + 1'b1)
                  || (level + 1'b1 == $past(level)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && full && !rd_req && quiet) |=> ovf_flag);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_tmo_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |-> !empty);

    p_tmo_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (tmo_cmp == '0 && !tmo_flag) |=> !tmo_flag);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !empty) |=> !tmo_flag);

    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty && !in_valid) |=> empty);

    p_push_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rd_req && !empty && quiet) |=> $stable(level));

    p_soft_reset_r9: assert property (@(posedge clk) disable iff (rst)
        sw_rst_req |=> (empty && sw_rst_busy));

endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_rxb_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .rd_req      (rd_req),
    .ovf_clr     (ovf_clr),
    .sw_rst_req  (sw_rst_req),
    .sw_rst_busy (sw_rst_busy),
    .tmo_cmp     (tmo_cmp),
    .level       (level),
    .empty       (empty),
    .full        (full),
    .ovf_flag    (ovf_flag),
    .tmo_flag    (tmo_flag)
);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [2:0] in_err = '0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [1:0] trig_sel = 2'd0;
    logic [8:0] tmo_cmp = '0;
    logic       baud_tick = 1'b0;
    logic       sw_rst_req = 1'b0;
    logic       sw_rst_busy;
    logic       ovf_clr = 1'b0;
    logic [4:0] level;
    logic       empty, full, ovf_flag, avail_flag, tmo_flag;

    int n_run = 0;
    int n_fail = 0;
    logic [10:0] model_q[$];
    logic [10:0] exp_q[$];
    logic        rd_fired = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_buffer i_uart_rx_buffer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_err(in_err),
        .rd_req(rd_req), .rd_data(rd_data), .rd_err(rd_err), .trig_sel(trig_sel),
        .tmo_cmp(tmo_cmp), .baud_tick(baud_tick), .sw_rst_req(sw_rst_req),
        .sw_rst_busy(sw_rst_busy), .ovf_clr(ovf_clr), .level(level), .empty(empty),
        .full(full), .ovf_flag(ovf_flag), .avail_flag(avail_flag), .tmo_flag(tmo_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compares read results against the scoreboard queue
    always @(posedge clk) rd_fired <= rd_req;

    always @(negedge clk) begin
        if (rd_fired) begin
            logic [10:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 11'h7FF;
            chk("R1 read data", int'(rd_data), int'(e[7:0]));
            chk("R1 read err", int'(rd_err), int'(e[10:8]));
        end
    end

    task automatic put(input logic [7:0] d, input logic [2:0] e, input bit ignored);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_err = e;
        if (!ignored && model_q.size() < 16) model_q.push_back({e, d});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic take();
        @(negedge clk);
        rd_req = 1'b1;
        exp_q.push_back((model_q.size() > 0) ? model_q.pop_front() : 11'h000);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic put_take(input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_err = 3'b010; rd_req = 1'b1;
        exp_q.push_back(model_q.pop_front());
        model_q.push_back({3'b010, d});
        @(negedge clk);
        in_valid = 1'b0; rd_req = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R2 reset empty", int'(empty), 1);
        chk("R2 reset full", int'(full), 0);
        chk("R2 reset level", int'(level), 0);
        chk("R3 reset ovf", int'(ovf_flag), 0);
        chk("R4 reset avail", int'(avail_flag), 0);
        chk("R5 reset tmo", int'(tmo_flag), 0);

        // R1/R2/R4: few bytes, varied error bits, trigger changes
        put(8'hA5, 3'b001, 0);
        chk("R4 avail at 1 with sel 0", int'(avail_flag), 1);
        trig_sel = 2'd1;
        put(8'h3C, 3'b100, 0);
        put(8'hFF, 3'b000, 0);
        chk("R2 level 3", int'(level), 3);
        chk("R2 not empty", int'(empty), 0);
        chk("R4 avail below 4", int'(avail_flag), 0);
        put(8'h01, 3'b111, 0);
        chk("R4 avail at 4", int'(avail_flag), 1);
        take();
        chk("R4 avail drops at 3", int'(avail_flag), 0);
        chk("R2 level after read", int'(level), 3);
        take(); take(); take();
        chk("R2 empty after drain", int'(empty), 1);

        // R7: empty read
        take();
        chk("R7 level stays 0", int'(level), 0);

        // R2/R3/R4/R8: fill, overflow, simultaneous ops when full
        trig_sel = 2'd2;
        for (int i = 0; i < 16; i++) begin
            put(8'(8'h10 + i), 3'(i), 0);
            if (i == 6) chk("R4 avail below 8", int'(avail_flag), 0);
            if (i == 7) chk("R4 avail at 8", int'(avail_flag), 1);
        end
        trig_sel = 2'd3;
        chk("R2 full at 16", int'(full), 1);
        chk("R2 level 16", int'(level), 16);
        chk("R4 avail at 16 sel 3", int'(avail_flag), 1);
        chk("R3 no ovf yet", int'(ovf_flag), 0);
        put(8'hEE, 3'b000, 1);
        chk("R3 ovf set", int'(ovf_flag), 1);
        chk("R3 level held", int'(level), 16);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R3 ovf cleared", int'(ovf_flag), 0);
        put_take(8'h77);
        chk("R8 level same when full", int'(level), 16);
        chk("R8 no ovf on push+pop", int'(ovf_flag), 0);
        take(); take();
        chk("R4 avail at 14", int'(avail_flag), 1);
        take();
        chk("R4 avail below 14", int'(avail_flag), 0);
        put_take(8'h88);
        chk("R8 level same mid", int'(level), 13);
        for (int i = 0; i < 13; i++) take();
        chk("R2 empty after full drain", int'(empty), 1);

        // R5/R6: idle time-out
        trig_sel = 2'd0;
        tmo_cmp = 9'd3;
        repeat (6) tick();
        chk("R5 no tmo when empty", int'(tmo_flag), 0);
        put(8'h42, 3'b000, 0);
        repeat (3) tick();
        chk("R5 tmo not yet after 3", int'(tmo_flag), 0);
        tick();
        chk("R5 tmo after 4 ticks", int'(tmo_flag), 1);
        put(8'h43, 3'b000, 0);
        chk("R6 flag kept over new byte", int'(tmo_flag), 1);
        take();
        chk("R6 read clears tmo", int'(tmo_flag), 0);
        repeat (3) tick();
        put(8'h44, 3'b000, 0);
        repeat (3) tick();
        chk("R6 byte restarts count", int'(tmo_flag), 0);
        tick();
        chk("R6 tmo after restart", int'(tmo_flag), 1);
        take(); take();
        tmo_cmp = 9'd0;
        put(8'h45, 3'b000, 0);
        repeat (20) tick();
        chk("R5 disabled with 0", int'(tmo_flag), 0);
        take();

        // R9: software reset
        for (int i = 0; i < 5; i++) put(8'(8'hC0 + i), 3'b000, 0);
        @(negedge clk); sw_rst_req = 1'b1; model_q.delete();
        @(negedge clk); sw_rst_req = 1'b0;
        chk("R9 level cleared", int'(level), 0);
        chk("R9 busy", int'(sw_rst_busy), 1);
        put(8'h99, 3'b000, 1);
        chk("R9 byte discarded", int'(level), 0);
        chk("R9 still busy", int'(sw_rst_busy), 1);
        @(negedge clk);
        chk("R9 busy released", int'(sw_rst_busy), 0);
        put(8'h5A, 3'b011, 0);
        chk("R9 accepts after reset", int'(level), 1);
        take();
        @(negedge clk);
        chk("R1 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule